// File: doc/BRIEF.md
# Serial Flash Memory-Window Read Engine

This block serves reads of a memory-mapped window from a serial flash, so that code and constants can be fetched in place. Software first stores a read-command template. The template gives the opcode, how many address bytes to send, how many dummy bytes follow, and whether data comes back on one line or on several. Storing a valid template puts the engine into memory mode and raises a ready flag. From then on, each window read is turned into a complete flash transaction: chip select falls, and the opcode, the address, the dummy clocks and the data phase follow. The requested bytes are then returned on the bus, and the bus is held until they are complete.

A reset request leaves memory mode so that a separate command sequencer can use the flash. The request is held pending while a transaction is still in flight. Window reads made outside memory mode complete at once with an error and return zero. Chip select is released after every transaction and stays high for a programmable minimum before the next one starts. The flash clock runs at half the system clock and idles low, which is SPI mode 0.

Top module: `flash_xip_reader`

## Requirements
- R1: After reset, the ready and reset-busy flags are 0, chip select is high, the flash clock is low, no line is driven and no acknowledge is given.
- R2: A register write with `reg_sel`=0 stores the template. Opcode is bits 31:24, frame code bits 23:21, field code bits 20:19 and dummy byte count bits 18:16. If the frame code is 2 to 5, ready is 1 one cycle later. Any other frame code makes ready 0.
- R3: A window read while ready is 0 is acknowledged on the next cycle with `win_err`=1 and data 0, and chip select never falls.
- R4: A transaction sends the opcode and then the low (frame code − 1) bytes of the window offset, most significant bit first, on line 0. Each bit is valid at the rising flash-clock edge.
- R5: After the address, 8 flash clocks are sent per dummy byte, and no line is driven during them or during the data phase.
- R6: With field code 1, data arrives on lines 1:0 when `cfg_dual`=1 and on lines 3:0 when it is 0, the higher line carrying the earlier bit. With any other field code, data arrives serially on line 1.
- R7: `win_size` 0, 1 and 2 request 1, 2 and 4 bytes. The first flash byte goes to bits 7:0 and later bytes go to higher bytes. Unrequested bytes read as 0.
- R8: With no pending gap, the acknowledge is a single-cycle pulse with `win_err`=0. It arrives exactly 2·N+1 cycles after the request is raised, where N is the number of flash clocks in the transaction.
- R9: Between two transactions, chip select stays high for at least `cfg_csh`+1 cycles. Back-to-back reads see exactly that gap.
- R10: A register write with `reg_sel`=1 and bit 4 set raises reset-busy. Once no transaction is in flight, busy and ready both drop on the next cycle. A transaction in progress completes normally first.
- R11: The flash clock is low whenever chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the template, 1 the status/reset register |
| reg_wdata | input | 32 | Register write data |
| cfg_dual | input | 1 | Wide data uses two lines when 1, four when 0 |
| cfg_csh | input | CSHW | Minimum chip-select-high gap, minus one |
| stat_ready | output | 1 | Memory mode active |
| stat_rst_busy | output | 1 | Reset request pending |
| win_req | input | 1 | Window read request, held until acknowledge |
| win_addr | input | AW | Window byte offset |
| win_size | input | 2 | Read size code |
| win_ack | output | 1 | Read complete |
| win_err | output | 1 | Read refused outside memory mode |
| win_rdata | output | 32 | Read data |
| fl_sck | output | 1 | Flash clock |
| fl_cs_n | output | 1 | Flash chip select, active low |
| fl_io_o | output | 4 | Flash line outputs |
| fl_io_oe | output | 4 | Flash line output enables |
| fl_io_i | input | 4 | Flash line inputs |

## Verification
The assertions assume that a requester keeps `win_req` and its address and size stable until the acknowledge, and then drops the request for at least one cycle. They also assume that `cfg_csh` and `cfg_dual` do not change while a transaction is in flight. The stimulus raises each request on a falling clock edge and lowers it in the cycle the acknowledge is seen. It changes the configuration only while the engine is idle and the previous gap has elapsed. The flash model answers from an address-derived byte pattern and records the opcode and address it receives. Template writes during a transaction are avoided, except for the reset request, which is issued mid-transfer on purpose.

// File: rtl/flash_xip_reader.sv
module flash_xip_reader #(
  parameter int AW   = 24,
  parameter int CSHW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic            reg_sel,
  input  logic [31:0]     reg_wdata,
  input  logic            cfg_dual,
  input  logic [CSHW-1:0] cfg_csh,
  output logic            stat_ready,
  output logic            stat_rst_busy,
  input  logic            win_req,
  input  logic [AW-1:0]   win_addr,
  input  logic [1:0]      win_size,
  output logic            win_ack,
  output logic            win_err,
  output logic [31:0]     win_rdata,
  output logic            fl_sck,
  output logic            fl_cs_n,
  output logic [3:0]      fl_io_o,
  output logic [3:0]      fl_io_oe,
  input  logic [3:0]      fl_io_i
);

  localparam int CW  = 7;
  localparam int SHW = 40;

  typedef enum logic [1:0] {S_IDLE, S_CMD, S_DUMMY, S_DATA} st_t;

  st_t              st;
  logic [15:0]      tmpl;
  logic             ready, rst_pend, ph, ack_q, err_q;
  logic [SHW-1:0]   sh;
  logic [31:0]      din, din_nx, rdata_q, a32;
  logic [CW-1:0]    cnt, dclk;
  logic [2:0]       dmy, lanes, nby;
  logic [CSHW-1:0]  gap;

  logic [7:0]    t_op;
  logic [2:0]    t_frm, t_dmy, nab, req_n, req_lanes;
  logic [1:0]    t_fld;
  logic [2:0]    w_frm;
  logic          w_ok;
  logic [CW-1:0] cmd_clks, req_dclk;
  logic          unused_bits;

  assign t_op   = tmpl[15:8];
  assign t_frm  = tmpl[7:5];
  assign t_fld  = tmpl[4:3];
  assign t_dmy  = tmpl[2:0];
  assign nab    = t_frm - 3'd1;
  assign w_frm  = reg_wdata[23:21];
  assign w_ok   = (w_frm >= 3'd2) && (w_frm <= 3'd5);
  assign unused_bits = ^{reg_wdata[15:5], reg_wdata[3:0]};

  assign req_n     = (win_size == 2'd0) ? 3'd1 : (win_size == 2'd1) ? 3'd2 : 3'd4;
  assign req_lanes = (t_fld == 2'd1) ? (cfg_dual ? 3'd2 : 3'd4) : 3'd1;
  assign cmd_clks  = CW'(8) + CW'({nab, 3'b000});
  assign a32       = 32'(win_addr);

  always_comb begin
    case (req_lanes)
      3'd2:    req_dclk = CW'({req_n, 2'b00});
      3'd4:    req_dclk = CW'({req_n, 1'b0});
      default: req_dclk = CW'({req_n, 3'b000});
    endcase
  end

  always_comb begin
    case (lanes)
      3'd2:    din_nx = {din[29:0], fl_io_i[1:0]};
      3'd4:    din_nx = {din[27:0], fl_io_i};
      default: din_nx = {din[30:0], fl_io_i[1]};
    endcase
  end

  function automatic logic [31:0] pack_le(input logic [31:0] r, input logic [2:0] n);
    logic [31:0] o;
    o = '0;
    for (int k = 0; k < 4; k++)
      if (k < int'(n)) o[k*8 +: 8] = 8'(r >> (8 * (int'(n) - 1 - k)));
    return o;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; tmpl <= '0; ready <= 1'b0; rst_pend <= 1'b0;
      ph <= 1'b0; fl_cs_n <= 1'b1; sh <= '0; din <= '0; cnt <= '0;
      dmy <= '0; lanes <= 3'd1; nby <= 3'd1; dclk <= '0; gap <= '0;
      ack_q <= 1'b0; err_q <= 1'b0; rdata_q <= '0;
    end else begin
      ack_q <= 1'b0;
      err_q <= 1'b0;
      if (reg_wr && !reg_sel) begin
        tmpl  <= reg_wdata[31:16];
        ready <= w_ok;
      end
      if (reg_wr && reg_sel && reg_wdata[4]) rst_pend <= 1'b1;
      if (gap != '0) gap <= gap - 1'b1;
      case (st)
        S_IDLE: begin
          if (rst_pend) begin
            ready    <= 1'b0;
            rst_pend <= 1'b0;
          end else if (win_req && !ack_q) begin
            if (!ready) begin
              ack_q   <= 1'b1;
              err_q   <= 1'b1;
              rdata_q <= '0;
            end else if (gap == '0) begin
              st      <= S_CMD;
              fl_cs_n <= 1'b0;
              ph      <= 1'b0;
              sh      <= {t_op, a32 << {3'd4 - nab, 3'b000}};
              cnt     <= cmd_clks;
              dmy     <= t_dmy;
              lanes   <= req_lanes;
              nby     <= req_n;
              dclk    <= req_dclk;
              din     <= '0;
            end
          end
        end
        default: begin
          if (!ph) ph <= 1'b1;
          else begin
            ph  <= 1'b0;
            cnt <= cnt - 1'b1;
            if (st == S_CMD) begin
              sh <= sh << 1;
              if (cnt == CW'(1)) begin
                if (dmy != 3'd0) begin
                  st  <= S_DUMMY;
                  cnt <= CW'({dmy, 3'b000});
                end else begin
                  st  <= S_DATA;
                  cnt <= dclk;
                end
              end
            end else if (st == S_DUMMY) begin
              if (cnt == CW'(1)) begin
                st  <= S_DATA;
                cnt <= dclk;
              end
            end else begin
              din <= din_nx;
              if (cnt == CW'(1)) begin
                st      <= S_IDLE;
                fl_cs_n <= 1'b1;
                gap     <= cfg_csh;
                ack_q   <= 1'b1;
                rdata_q <= pack_le(din_nx, nby);
              end
            end
          end
        end
      endcase
    end
  end

  assign stat_ready    = ready;
  assign stat_rst_busy = rst_pend;
  assign win_ack       = ack_q;
  assign win_err       = err_q;
  assign win_rdata     = rdata_q;
  assign fl_sck        = ph;
  assign fl_io_o       = {3'b000, sh[SHW-1]};
  assign fl_io_oe      = {3'b000, st == S_CMD};

  logic [CSHW:0] hi_cnt;
  logic          had_xfer;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt   <= '0;
      had_xfer <= 1'b0;
    end else begin
      if (!fl_cs_n) begin
        hi_cnt   <= '0;
        had_xfer <= 1'b1;
      end else if (hi_cnt != '1) hi_cnt <= hi_cnt + 1'b1;
    end
  end

  AST_SCK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    fl_cs_n |-> !fl_sck); // R11
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    win_ack |=> !win_ack); // R8
  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    win_err |-> (win_ack && win_rdata == '0)); // R3
  AST_START_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fl_cs_n) |-> $past(stat_ready)); // R3
  AST_DRIVE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_io_oe != 4'h0) |-> !fl_cs_n); // R4
  AST_CS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (had_xfer && $fell(fl_cs_n)) |-> (hi_cnt >= {1'b0, cfg_csh} + 1'b1)); // R9
  AST_RST_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat_rst_busy) |-> !stat_ready); // R10
  AST_RST_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rst_busy && !fl_cs_n) |=> stat_rst_busy); // R10

endmodule

// File: tb/tb_flash_xip_reader.sv
module tb_flash_xip_reader;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;

  localparam logic [63:0] VEC [NV] = '{
    {8'h03, 3'd4, 2'd0, 3'd0, 16'h0, 1'b0, 2'd2, 5'd0, 24'h000100},
    {8'h0B, 3'd4, 2'd0, 3'd1, 16'h0, 1'b0, 2'd0, 5'd0, 24'h001234},
    {8'h3B, 3'd4, 2'd1, 3'd1, 16'h0, 1'b1, 2'd2, 5'd0, 24'h00ABCD},
    {8'h6B, 3'd4, 2'd1, 3'd1, 16'h0, 1'b0, 2'd1, 5'd0, 24'h7F0011},
    {8'hEB, 3'd2, 2'd1, 3'd3, 16'h0, 1'b0, 2'd2, 5'd0, 24'h0000FE},
    {8'h13, 3'd5, 2'd0, 3'd0, 16'h0, 1'b0, 2'd1, 5'd0, 24'hFFFFFF},
    {8'hBB, 3'd3, 2'd1, 3'd2, 16'h0, 1'b1, 2'd0, 5'd0, 24'h123456},
    {8'h0C, 3'd5, 2'd2, 3'd0, 16'h0, 1'b1, 2'd2, 5'd0, 24'h000003}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic cfg_dual = 1'b0;
  logic [3:0] cfg_csh = 4'd3;
  logic stat_ready, stat_rst_busy;
  logic win_req = 1'b0;
  logic [23:0] win_addr = '0;
  logic [1:0] win_size = '0;
  logic win_ack, win_err;
  logic [31:0] win_rdata;
  logic fl_sck, fl_cs_n;
  logic [3:0] fl_io_o, fl_io_oe;
  logic [3:0] fl_io_i = 4'h0;

  int n_chk = 0, n_bad = 0;
  int m_cnt = 0, m_pre = 0, m_cmdb = 0, m_lanes = 1, m_oe_bad = 0;
  logic [39:0] m_cap = '0;
  logic [31:0] m_base = '0;
  int hi_run = 0, last_gap = 0, sck_bad = 0, cs_falls = 0;

  flash_xip_reader #(.AW(24), .CSHW(4)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .cfg_dual(cfg_dual), .cfg_csh(cfg_csh), .stat_ready(stat_ready), .stat_rst_busy(stat_rst_busy),
    .win_req(win_req), .win_addr(win_addr), .win_size(win_size), .win_ack(win_ack),
    .win_err(win_err), .win_rdata(win_rdata), .fl_sck(fl_sck), .fl_cs_n(fl_cs_n),
    .fl_io_o(fl_io_o), .fl_io_oe(fl_io_oe), .fl_io_i(fl_io_i));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] mb(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h3C;
  endfunction

  always @(posedge fl_sck or negedge fl_cs_n) begin
    if (!fl_sck) begin
      m_cnt = 0;
      m_cap = '0;
    end else begin
      if (m_cnt < m_cmdb) m_cap = {m_cap[38:0], fl_io_o[0]};
      else if (fl_io_oe != 4'h0) m_oe_bad++;
      m_cnt++;
    end
  end

  always @(negedge fl_sck) begin
    int j, b, s;
    logic [7:0] by, v;
    j = m_cnt - m_pre;
    if (!fl_cs_n && j >= 0) begin
      b  = j * m_lanes;
      by = mb(m_base + 32'(b / 8));
      s  = 8 - m_lanes - (b % 8);
      v  = by >> s;
      case (m_lanes)
        2:       fl_io_i = {2'b00, v[1:0]};
        4:       fl_io_i = v[3:0];
        default: fl_io_i = {2'b00, v[0], 1'b0};
      endcase
    end
  end

  always @(negedge fl_cs_n) cs_falls++;

  always @(negedge clk) begin
    if (fl_cs_n && fl_sck) sck_bad++;
    if (fl_cs_n) hi_run++;
    else begin
      if (hi_run > 0) last_gap = hi_run;
      hi_run = 0;
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic wr_reg(input logic sel, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic do_read(input logic [23:0] a, input logic [1:0] sz,
                         output logic [31:0] rd, output logic er, output int lat);
    @(negedge clk);
    win_addr = a; win_size = sz; win_req = 1'b1; lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!win_ack);
    rd = win_rdata; er = win_err; win_req = 1'b0;
  endtask

  task automatic set_model(input logic [31:0] t, input logic dual, input logic [23:0] a);
    int nab;
    nab = int'(t[23:21]) - 1;
    m_cmdb  = 8 + 8 * nab;
    m_pre   = m_cmdb + 8 * int'(t[18:16]);
    m_lanes = (t[20:19] == 2'd1) ? (dual ? 2 : 4) : 1;
    m_base  = 32'(a);
  endtask

  function automatic logic [31:0] exp_data(input logic [23:0] a, input logic [1:0] sz);
    logic [31:0] e;
    int n;
    n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    e = '0;
    for (int k = 0; k < n; k++) e[k*8 +: 8] = mb(32'(a) + 32'(k));
    return e;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] rd, t;
    logic er;
    int lat, falls0, nab, n, c;
    repeat (3) @(negedge clk);
    chk(stat_ready == 0 && stat_rst_busy == 0, "R1 flags", {stat_ready, stat_rst_busy}, 0);
    chk(fl_cs_n == 1 && fl_sck == 0 && fl_io_oe == 0 && win_ack == 0, "R1 pins",
        {fl_cs_n, fl_sck, fl_io_oe, win_ack}, 7'b1000000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    falls0 = cs_falls;
    do_read(24'h000040, 2'd2, rd, er, lat);
    chk(er == 1 && rd == 0, "R3 error data", {er, rd}, {1'b1, 32'h0});
    chk(lat == 1, "R3 error latency", lat, 1);
    chk(cs_falls == falls0, "R3 no select", cs_falls, falls0);

    wr_reg(1'b0, {8'h03, 3'd1, 2'd0, 3'd0, 16'h0});
    chk(stat_ready == 0, "R2 frame code 1 rejected", stat_ready, 0);
    wr_reg(1'b0, {8'h03, 3'd6, 2'd0, 3'd0, 16'h0});
    chk(stat_ready == 0, "R2 frame code 6 rejected", stat_ready, 0);
    do_read(24'h000010, 2'd0, rd, er, lat);
    chk(er == 1 && cs_falls == falls0, "R3 after bad template", {er, cs_falls}, {1'b1, falls0});

    for (int i = 0; i < NV; i++) begin
      t = VEC[i][63:32];
      cfg_dual = VEC[i][31];
      wr_reg(1'b0, t);
      chk(stat_ready == 1, "R2 ready after template", stat_ready, 1);
      set_model(t, VEC[i][31], VEC[i][23:0]);
      do_read(VEC[i][23:0], VEC[i][30:29], rd, er, lat);
      chk(rd == exp_data(VEC[i][23:0], VEC[i][30:29]), "R6 R7 data", rd, exp_data(VEC[i][23:0], VEC[i][30:29]));
      chk(er == 0, "R8 no error", er, 0);
      nab = int'(t[23:21]) - 1;
      chk(64'(m_cap) >> (8 * nab) == 64'(t[31:24]), "R4 opcode", 64'(m_cap) >> (8 * nab), t[31:24]);
      chk((64'(m_cap) & ((64'h1 << (8 * nab)) - 1)) == (64'(VEC[i][23:0]) & ((64'h1 << (8 * nab)) - 1)),
          "R4 address", 64'(m_cap) & ((64'h1 << (8 * nab)) - 1), 64'(VEC[i][23:0]) & ((64'h1 << (8 * nab)) - 1));
      n = (VEC[i][30:29] == 2'd0) ? 1 : (VEC[i][30:29] == 2'd1) ? 2 : 4;
      c = m_pre + (n * 8) / m_lanes;
      chk(lat == 2 * c + 1, "R5 R8 latency", lat, 2 * c + 1);
      repeat (20) @(negedge clk);
    end
    chk(m_oe_bad == 0, "R5 R6 lines released", m_oe_bad, 0);

    t = VEC[0][63:32];
    cfg_dual = 1'b0;
    cfg_csh = 4'd9;
    wr_reg(1'b0, t);
    set_model(t, 1'b0, 24'h000200);
    do_read(24'h000200, 2'd0, rd, er, lat);
    set_model(t, 1'b0, 24'h000201);
    do_read(24'h000201, 2'd0, rd, er, lat);
    chk(last_gap == 10, "R9 select gap", last_gap, 10);
    chk(rd == exp_data(24'h000201, 2'd0), "R9 second read data", rd, exp_data(24'h000201, 2'd0));
    cfg_csh = 4'd3;
    repeat (20) @(negedge clk);

    wr_reg(1'b1, 32'h0000_0010);
    chk(stat_rst_busy == 1, "R10 busy raised", stat_rst_busy, 1);
    @(negedge clk);
    chk(stat_rst_busy == 0 && stat_ready == 0, "R10 idle reset", {stat_rst_busy, stat_ready}, 0);
    do_read(24'h000300, 2'd2, rd, er, lat);
    chk(er == 1 && rd == 0, "R10 read after reset errors", {er, rd}, {1'b1, 32'h0});

    wr_reg(1'b0, t);
    set_model(t, 1'b0, 24'h000400);
    fork
      do_read(24'h000400, 2'd2, rd, er, lat);
      begin
        repeat (20) @(negedge clk);
        wr_reg(1'b1, 32'h0000_0010);
        chk(stat_rst_busy == 1 && fl_cs_n == 0, "R10 deferred", {stat_rst_busy, fl_cs_n}, 2'b10);
      end
    join
    chk(er == 0 && rd == exp_data(24'h000400, 2'd2), "R10 transfer finishes", rd, exp_data(24'h000400, 2'd2));
    chk(stat_rst_busy == 1, "R10 still busy at ack", stat_rst_busy, 1);
    @(negedge clk);
    chk(stat_rst_busy == 0 && stat_ready == 0, "R10 cleared after transfer", {stat_rst_busy, stat_ready}, 0);

    chk(sck_bad == 0, "R11 clock idle", sck_bad, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule